// File: doc/BRIEF.md
# On-Screen Display Pixel Level Mixer

The block chooses, one pixel per clock, the output level code that goes to an external video DAC while text is drawn over a picture. It receives the glyph dot for the current pixel, the two attribute bits of the current character cell, the position flags from the display timing (sync, the video blanking interval, inside the text window, inside an occupied cell, the text row number) and the settings held by the display control registers. From these it picks one of eight codes: sync, pedestal, deep or grey blanking, bright or dim character, cell backdrop, or pass-through of the incoming video.

The block holds the flash timer. A field strobe arrives once per video field, and the timer counts these strobes to set the flash phase. The half period in fields depends on the selected flash speed and on the field rate. The block also decides which pixels the selected blanking region covers, and drives a per-row halftone control line.

Every result is registered once. The code on `level_o` and the value on `halftone_o` therefore belong to the inputs that were present one clock earlier.

Top module: `osd_pixel_mixer`

## Requirements
- R1: While `sync_i` is 1 the level code one clock later is 1 (sync), whatever the other inputs are.
- R2: While `video_blank_i` is 1 and `sync_i` is 0, the level code is 2 (pedestal).
- R3: Outside sync and the blanking interval, with `disp_on_i` at 0, the level code is 0 (pass the input video through unchanged).
- R4: Inside an occupied cell, the effective dot is `dot_i` XOR `attr_i[0]` (reverse video). A set effective dot gives code 5 (about 95 IRE) when `char_bright_i` is 1, and code 6 (about 75 IRE) when it is 0.
- R5: With `attr_i[1]` at 1 and `flash_sel_i` at 0 (highlight), a cell pixel whose effective dot is clear gives code 7 (backdrop).
- R6: `blank_mode_i` selects the region that is covered: 0 none, 1 occupied cells, 2 the text window, 3 the whole active picture. A covered pixel with no higher-priority result gives code 3 (about 5 IRE) when `blank_deep_i` is 1, and code 4 (about 15 IRE) when it is 0. A pixel that is not covered gives code 0.
- R7: With `attr_i[1]` at 1 and `flash_sel_i` at 1, the cell flashes with a 50% duty. The phase starts visible after reset. It inverts after every H field strobes, where H is 15 (fast, 60 Hz), 12 (fast, 50 Hz), 30 (slow, 60 Hz) or 25 (slow, 50 Hz). `flash_slow_i` selects the speed and `rate50_i` selects the field rate. While the phase is hidden, the cell shows the blanking code if its pixel is covered, and code 0 if it is not.
- R8: `halftone_o` is 1 only when the display is on, the pixel is in the text window outside sync and blanking, and the mask bit for the row is set. The row number `row_i` runs from 0 to 11. With `half_upper_i` at 0, mask bit n serves row n for rows 0 to 5. With `half_upper_i` at 1, mask bit n serves row n+6. Any other row gives 0.
- R9: During reset and on the first clock after it, `level_o` is 0 and `halftone_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_strobe_i | input | 1 | One-clock pulse per video field |
| rate50_i | input | 1 | Field rate: 1 = 50 Hz, 0 = 60 Hz |
| flash_slow_i | input | 1 | Flash speed: 1 = about 1 s, 0 = about 0.5 s |
| flash_sel_i | input | 1 | Meaning of attribute bit 1: 1 = flash, 0 = highlight |
| disp_on_i | input | 1 | Character display enable |
| blank_mode_i | input | 2 | Blanking region select |
| char_bright_i | input | 1 | Character level: 1 = bright, 0 = dim |
| blank_deep_i | input | 1 | Blanking level: 1 = deep, 0 = grey |
| half_mask_i | input | 6 | Halftone enable bits for six rows |
| half_upper_i | input | 1 | Routes the mask to the upper six rows |
| sync_i | input | 1 | Pixel lies in a sync pulse |
| video_blank_i | input | 1 | Pixel lies in the video blanking interval |
| in_window_i | input | 1 | Pixel lies inside the text window |
| in_cell_i | input | 1 | Pixel lies inside an occupied character cell |
| row_i | input | 4 | Text row of the pixel |
| dot_i | input | 1 | Glyph dot from the font store |
| attr_i | input | 2 | Cell attributes: bit 0 reverse, bit 1 highlight/flash |
| level_o | output | 3 | Registered level code |
| halftone_o | output | 1 | Registered halftone line |

## Verification
Both the level code and the halftone line are due exactly one clock after the inputs that produce them. The bench changes inputs on the falling edge, lets a single rising edge pass, and compares on the next falling edge. A flash phase change takes effect on the field strobe edge, and the cell output reflects it one edge later. For that reason the flash checks add one step after the last strobe before they compare. They also compare just before the strobe that is due to invert the phase, so that a change one field early or one field late is detected.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

    typedef enum logic [2:0] {
        LV_VIDEO       = 3'd0,
        LV_SYNC        = 3'd1,
        LV_PEDESTAL    = 3'd2,
        LV_BLANK_DEEP  = 3'd3,
        LV_BLANK_GREY  = 3'd4,
        LV_CHAR_BRIGHT = 3'd5,
        LV_CHAR_DIM    = 3'd6,
        LV_BACKDROP    = 3'd7
    } level_e;

    typedef enum logic [1:0] {
        BLK_NONE   = 2'd0,
        BLK_CELL   = 2'd1,
        BLK_WINDOW = 2'd2,
        BLK_SCREEN = 2'd3
    } blank_e;

    typedef struct packed {
        level_e level;
        logic   halftone;
    } pix_out_s;

endpackage

// File: rtl/osd_flash_timer.sv
module osd_flash_timer #(
    parameter int FAST_HALF_60 = 15,
    parameter int FAST_HALF_50 = 12,
    parameter int SLOW_HALF_60 = 30,
    parameter int SLOW_HALF_50 = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_strobe_i,
    input  logic rate50_i,
    input  logic flash_slow_i,
    output logic visible_o
);
    localparam int MAX_A = (FAST_HALF_60 > FAST_HALF_50) ? FAST_HALF_60 : FAST_HALF_50;
    localparam int MAX_B = (SLOW_HALF_60 > SLOW_HALF_50) ? SLOW_HALF_60 : SLOW_HALF_50;
    localparam int MAX_H = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_H + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          visible;
    } tmr_s;

    tmr_s          tmr_d, tmr_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        unique case ({flash_slow_i, rate50_i})
            2'b00:   last_cnt = CW'(FAST_HALF_60 - 1);
            2'b01:   last_cnt = CW'(FAST_HALF_50 - 1);
            2'b10:   last_cnt = CW'(SLOW_HALF_60 - 1);
            default: last_cnt = CW'(SLOW_HALF_50 - 1);
        endcase
    end

    always_comb begin
        tmr_d = tmr_q;
        if (field_strobe_i) begin
            if (tmr_q.cnt >= last_cnt) begin
                tmr_d.cnt     = '0;
                tmr_d.visible = ~tmr_q.visible;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt     <= '0;
            tmr_q.visible <= 1'b1;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign visible_o = tmr_q.visible;

    // R7: the phase never moves between field strobes
    a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !field_strobe_i |=> $stable(visible_o));

    // R7: the strobe that completes a half period inverts the phase
    a_r7_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (field_strobe_i && tmr_q.cnt >= last_cnt) |=> (visible_o != $past(visible_o)));

endmodule

// File: rtl/osd_blank_region.sv
module osd_blank_region
    import osd_mix_pkg::*;
(
    input  logic [1:0] blank_mode_i,
    input  logic       in_window_i,
    input  logic       in_cell_i,
    output logic       covered_o
);
    always_comb begin
        unique case (blank_e'(blank_mode_i))
            BLK_NONE:   covered_o = 1'b0;
            BLK_CELL:   covered_o = in_cell_i;
            BLK_WINDOW: covered_o = in_window_i;
            default:    covered_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/osd_halftone.sv
module osd_halftone #(
    parameter int ROWS  = 12,
    parameter int ROW_W = $clog2(ROWS),
    parameter int HALF  = ROWS / 2
) (
    input  logic [ROW_W-1:0] row_i,
    input  logic [HALF-1:0]  mask_i,
    input  logic             upper_i,
    output logic             row_on_o
);
    logic [HALF-1:0] pick;

    for (genvar n = 0; n < HALF; n++) begin : g_row
        assign pick[n] = mask_i[n] &&
                         (int'(row_i) == (upper_i ? n + HALF : n));
    end

    assign row_on_o = |pick;
endmodule

// File: rtl/osd_level_select.sv
module osd_level_select
    import osd_mix_pkg::*;
(
    input  logic   sync_i,
    input  logic   video_blank_i,
    input  logic   disp_on_i,
    input  logic   in_cell_i,
    input  logic   dot_i,
    input  logic [1:0] attr_i,
    input  logic   flash_sel_i,
    input  logic   visible_i,
    input  logic   covered_i,
    input  logic   char_bright_i,
    input  logic   blank_deep_i,
    output level_e level_o
);
    logic   eff_dot, flashing, highlight, hidden;
    level_e blank_lvl, char_lvl;

    always_comb begin
        eff_dot   = dot_i ^ attr_i[0];
        flashing  = attr_i[1] & flash_sel_i;
        highlight = attr_i[1] & ~flash_sel_i;
        hidden    = in_cell_i & flashing & ~visible_i;
        blank_lvl = blank_deep_i ? LV_BLANK_DEEP : LV_BLANK_GREY;
        char_lvl  = char_bright_i ? LV_CHAR_BRIGHT : LV_CHAR_DIM;

        if (sync_i)                       level_o = LV_SYNC;
        else if (video_blank_i)           level_o = LV_PEDESTAL;
        else if (!disp_on_i)              level_o = LV_VIDEO;
        else if (hidden)                  level_o = covered_i ? blank_lvl : LV_VIDEO;
        else if (in_cell_i && eff_dot)    level_o = char_lvl;
        else if (in_cell_i && highlight)  level_o = LV_BACKDROP;
        else if (covered_i)               level_o = blank_lvl;
        else                              level_o = LV_VIDEO;
    end
endmodule

// File: rtl/osd_pixel_mixer.sv
module osd_pixel_mixer
    import osd_mix_pkg::*;
#(
    parameter int ROWS         = 12,
    parameter int FAST_HALF_60 = 15,
    parameter int FAST_HALF_50 = 12,
    parameter int SLOW_HALF_60 = 30,
    parameter int SLOW_HALF_50 = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_strobe_i,
    input  logic       rate50_i,
    input  logic       flash_slow_i,
    input  logic       flash_sel_i,
    input  logic       disp_on_i,
    input  logic [1:0] blank_mode_i,
    input  logic       char_bright_i,
    input  logic       blank_deep_i,
    input  logic [5:0] half_mask_i,
    input  logic       half_upper_i,
    input  logic       sync_i,
    input  logic       video_blank_i,
    input  logic       in_window_i,
    input  logic       in_cell_i,
    input  logic [3:0] row_i,
    input  logic       dot_i,
    input  logic [1:0] attr_i,
    output logic [2:0] level_o,
    output logic       halftone_o
);
    localparam int ROW_W = 4;
    localparam int HALF  = ROWS / 2;

    logic     visible, covered, row_on;
    level_e   level_c;
    pix_out_s out_d, out_q;

    osd_flash_timer #(
        .FAST_HALF_60 (FAST_HALF_60),
        .FAST_HALF_50 (FAST_HALF_50),
        .SLOW_HALF_60 (SLOW_HALF_60),
        .SLOW_HALF_50 (SLOW_HALF_50)
    ) flash_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .field_strobe_i (field_strobe_i),
        .rate50_i       (rate50_i),
        .flash_slow_i   (flash_slow_i),
        .visible_o      (visible)
    );

    osd_blank_region region_i (
        .blank_mode_i (blank_mode_i),
        .in_window_i  (in_window_i),
        .in_cell_i    (in_cell_i),
        .covered_o    (covered)
    );

    osd_halftone #(.ROWS(ROWS), .ROW_W(ROW_W), .HALF(HALF)) half_i (
        .row_i    (row_i),
        .mask_i   (half_mask_i[HALF-1:0]),
        .upper_i  (half_upper_i),
        .row_on_o (row_on)
    );

    osd_level_select select_i (
        .sync_i        (sync_i),
        .video_blank_i (video_blank_i),
        .disp_on_i     (disp_on_i),
        .in_cell_i     (in_cell_i),
        .dot_i         (dot_i),
        .attr_i        (attr_i),
        .flash_sel_i   (flash_sel_i),
        .visible_i     (visible),
        .covered_i     (covered),
        .char_bright_i (char_bright_i),
        .blank_deep_i  (blank_deep_i),
        .level_o       (level_c)
    );

    always_comb begin
        out_d.level    = level_c;
        out_d.halftone = row_on && disp_on_i && in_window_i && !sync_i && !video_blank_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.level    <= LV_VIDEO;
            out_q.halftone <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign level_o    = out_q.level;
    assign halftone_o = out_q.halftone;

    // R1: sync wins over every other input
    a_r1_sync_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (level_o == LV_SYNC));

    // R3: display off passes the video through
    a_r3_display_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && !video_blank_i && !disp_on_i) |=> (level_o == LV_VIDEO));

    // R8: rows beyond the last text row never get halftone
    a_r8_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(row_i) >= ROWS) |=> !halftone_o);

endmodule

// File: tb/osd_pixel_mixer_tb_top.sv
module osd_pixel_mixer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       field_strobe_i = 1'b0, rate50_i = 1'b0, flash_slow_i = 1'b0;
    logic       flash_sel_i = 1'b0, disp_on_i = 1'b0, char_bright_i = 1'b0;
    logic       blank_deep_i = 1'b0, half_upper_i = 1'b0;
    logic [1:0] blank_mode_i = 2'd0, attr_i = 2'd0;
    logic [5:0] half_mask_i = 6'd0;
    logic       sync_i = 1'b0, video_blank_i = 1'b0, in_window_i = 1'b0;
    logic       in_cell_i = 1'b0, dot_i = 1'b0;
    logic [3:0] row_i = 4'd0;
    logic [2:0] level_o;
    logic       halftone_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    osd_pixel_mixer dut_i (
        .clk(clk), .rst_n(rst_n), .field_strobe_i(field_strobe_i),
        .rate50_i(rate50_i), .flash_slow_i(flash_slow_i), .flash_sel_i(flash_sel_i),
        .disp_on_i(disp_on_i), .blank_mode_i(blank_mode_i),
        .char_bright_i(char_bright_i), .blank_deep_i(blank_deep_i),
        .half_mask_i(half_mask_i), .half_upper_i(half_upper_i),
        .sync_i(sync_i), .video_blank_i(video_blank_i), .in_window_i(in_window_i),
        .in_cell_i(in_cell_i), .row_i(row_i), .dot_i(dot_i), .attr_i(attr_i),
        .level_o(level_o), .halftone_o(halftone_o)
    );

    // {sync, vblank, disp, window, cell, dot, attr[1:0], flash_sel, bright, deep, mode[1:0], expected[2:0]}
    localparam logic [15:0] VEC [16] = '{
        16'b1_0_1_1_1_1_00_0_1_0_00_001, // R1 sync
        16'b0_1_1_1_1_1_00_0_1_0_00_010, // R2 pedestal
        16'b0_0_0_1_1_1_00_0_1_0_11_000, // R3 display off
        16'b0_0_1_1_1_1_00_0_1_0_00_101, // R4 bright dot
        16'b0_0_1_1_1_1_00_0_0_0_00_110, // R4 dim dot
        16'b0_0_1_1_1_0_01_0_1_0_00_101, // R4 reverse of a clear dot
        16'b0_0_1_1_1_1_01_0_1_0_00_000, // R4 reverse of a set dot
        16'b0_0_1_1_1_1_01_0_1_1_01_011, // R6 reversed dot, cell blank deep
        16'b0_0_1_1_1_0_10_0_1_0_00_111, // R5 highlight backdrop
        16'b0_0_1_1_1_1_10_0_0_0_00_110, // R5 highlight keeps the dot
        16'b0_0_1_1_0_0_00_0_1_0_01_000, // R6 cell mode, no cell
        16'b0_0_1_1_0_0_00_0_1_0_10_100, // R6 window mode grey
        16'b0_0_1_0_0_0_00_0_1_0_10_000, // R6 window mode outside
        16'b0_0_1_0_0_0_00_0_1_1_11_011, // R6 whole screen deep
        16'b0_0_1_1_1_1_10_1_1_0_00_101, // R7 flashing cell visible
        16'b0_0_1_1_1_0_00_0_1_0_00_000  // R6 mode off, empty cell pixel
    };

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input logic [15:0] v);
        {sync_i, video_blank_i, disp_on_i, in_window_i, in_cell_i, dot_i,
         attr_i, flash_sel_i, char_bright_i, blank_deep_i, blank_mode_i} = v[15:3];
    endtask

    task automatic strobes(input int n);
        for (int k = 0; k < n; k++) begin
            field_strobe_i = 1'b1;
            step();
            field_strobe_i = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        sync_i = 1'b1; disp_on_i = 1'b1; in_window_i = 1'b1; half_mask_i = 6'h3F;
        step();
        step();
        chk("R9 level in reset", int'(level_o), 0);
        chk("R9 halftone in reset", int'(halftone_o), 0);
        rst_n = 1'b1;
        sync_i = 1'b0;
        half_mask_i = 6'd0;
        step();
        chk("R9 level first cycle", int'(level_o), 0);

        // table walk
        for (int i = 0; i < 16; i++) begin
            apply(VEC[i]);
            step();
            chk($sformatf("R1-6 vector %0d", i), int'(level_o), int'(VEC[i][2:0]));
        end

        // R7 fast flash at 60 Hz: half period of 15 fields
        apply(16'b0_0_1_1_1_1_10_1_1_1_01_000);
        rate50_i = 1'b0; flash_slow_i = 1'b0;
        strobes(14);
        step();
        chk("R7 fast60 visible after 14", int'(level_o), 5);
        strobes(1);
        step();
        chk("R7 fast60 hidden covered", int'(level_o), 3);
        blank_mode_i = 2'd0;
        step();
        chk("R7 hidden uncovered video", int'(level_o), 0);
        strobes(14);
        step();
        chk("R7 still hidden after 29", int'(level_o), 0);
        strobes(1);
        step();
        chk("R7 visible after 30", int'(level_o), 5);

        // R7 slow flash at 50 Hz: half period of 25 fields
        do_reset();
        rate50_i = 1'b1; flash_slow_i = 1'b1; blank_mode_i = 2'd2; blank_deep_i = 1'b0;
        strobes(24);
        step();
        chk("R7 slow50 visible after 24", int'(level_o), 5);
        strobes(1);
        step();
        chk("R7 slow50 hidden grey", int'(level_o), 4);

        // R7 fast flash at 50 Hz: half period of 12 fields
        do_reset();
        rate50_i = 1'b1; flash_slow_i = 1'b0;
        strobes(11);
        step();
        chk("R7 fast50 visible after 11", int'(level_o), 5);
        strobes(1);
        step();
        chk("R7 fast50 hidden", int'(level_o), 4);

        // R8 halftone rows
        do_reset();
        apply(16'b0_0_1_1_0_0_00_0_1_0_00_000);
        row_i = 4'd3; half_mask_i = 6'b001000; half_upper_i = 1'b0;
        step();
        chk("R8 lower row 3 on", int'(halftone_o), 1);
        half_upper_i = 1'b1;
        step();
        chk("R8 upper routing row 3 off", int'(halftone_o), 0);
        row_i = 4'd9;
        step();
        chk("R8 upper row 9 on", int'(halftone_o), 1);
        half_upper_i = 1'b0;
        step();
        chk("R8 lower routing row 9 off", int'(halftone_o), 0);
        row_i = 4'd12; half_upper_i = 1'b1; half_mask_i = 6'h3F;
        step();
        chk("R8 row 12 off", int'(halftone_o), 0);
        row_i = 4'd6;
        in_window_i = 1'b0;
        step();
        chk("R8 outside window off", int'(halftone_o), 0);
        in_window_i = 1'b1;
        sync_i = 1'b1;
        step();
        chk("R8 during sync off", int'(halftone_o), 0);
        chk("R1 sync level", int'(level_o), 1);
        sync_i = 1'b0;
        step();
        chk("R8 row 6 upper on", int'(halftone_o), 1);
        disp_on_i = 1'b0;
        step();
        chk("R8 display off", int'(halftone_o), 0);

        finish_run();
    end

endmodule